// File: doc/BRIEF.md
# Grid Connection Sequencer

This block walks a grid-tied converter from standby to full power output. It first waits until the sensed grid amplitude, frequency and unbalance all sit inside their limits. It then waits for the phase-locked loop to stay steady for a dwell period. Next it closes the connection at a small trial power level and watches the current and protection flags for a fixed check period. Only after a clean trial does it move the power reference toward the requested target, at a bounded step per clock tick.

From the dwell stage onward, the block keeps checking four things: amplitude, frequency, frequency slew between successive samples, and phase error. If any one of them falls outside its limit, the block drops the connection and the power reference in the same clock edge and stores a cause code. It then holds off for a fixed time before it goes back to the window checks.

All limits and times are elaboration parameters. Each clock cycle counts as one sample and one tick.

Top module: `grid_sync_seq`

## Requirements
- R1: After reset, `state` is 0, `connect` is 0, `p_ref` is 0 and `trip_code` is 0. The state encoding is: 0 window wait, 1 lock dwell, 2 trial, 3 ramp, 4 run, 5 tripped.
- R2: In state 0, the block moves to state 1 on the next edge only if all three of these hold: AMP_MIN <= amp <= AMP_MAX, FREQ_MIN <= freq <= FREQ_MAX, and unbal <= UNBAL_MAX. Otherwise it stays in state 0.
- R3: In state 1, the block moves to state 2 after DWELL consecutive stable cycles. A stable cycle has pll_lock=1 and |phase_err| <= LOCK_ERR_MAX. Any unstable cycle restarts the count.
- R4: The block enters state 2 with p_ref = TRIAL_P. After TRIAL_LEN cycles with cur_fault and prot_fault both low, it moves to state 3. Either fault flag high in any of those cycles leads to state 5 with trip code 5.
- R5: In states 3 and 4, p_ref moves toward p_target by min(STEP, |p_target - p_ref|) each cycle. State 3 changes to state 4 on the edge where p_ref becomes equal to p_target. In state 4, p_ref keeps following the target at the same limited rate.
- R6: In states 1 to 4, an amplitude outside [AMP_MIN, AMP_MAX] trips with code 1. A frequency outside [FREQ_MIN, FREQ_MAX] trips with code 2.
- R7: In states 1 to 4, |freq - freq of the previous cycle| > ROCOF_MAX trips with code 3. A difference equal to the limit does not trip.
- R8: In states 1 to 4, |phase_err| > PJUMP_MAX trips with code 4. phase_err is two's complement.
- R9: When several causes are present in the same cycle, the lowest code wins: 1 before 2, 2 before 3, 3 before 4, 4 before 5. trip_code keeps its value until the next trip.
- R10: On the edge that enters state 5, connect and p_ref go to 0. The block stays in state 5 for HOLDOFF cycles, whatever the inputs are, and then returns to state 0.
- R11: connect is 1 exactly in states 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one sample/tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| amp | input | AW | Measured grid amplitude |
| freq | input | FW | Measured grid frequency |
| unbal | input | UW | Measured unbalance |
| pll_lock | input | 1 | Lock indication from the PLL |
| phase_err | input | PEW | Signed PLL phase error |
| cur_fault | input | 1 | Abnormal current behaviour flag |
| prot_fault | input | 1 | Protection flag |
| p_target | input | PW | Requested active power |
| connect | output | 1 | Permission to connect to the grid |
| p_ref | output | PW | Power reference to the current loops |
| state | output | 3 | Sequencer stage code |
| trip_code | output | 3 | Cause of the latest trip |

## Verification
The bench builds the block with 8-bit words and these settings:
- amplitude window 100..150 and frequency window 60..80
- unbalance limit 10, slew limit 3, jump limit 40, lock limit 5
- DWELL 4, TRIAL_LEN 3, TRIAL_P 10, STEP 7, HOLDOFF 5

With 8-bit words, the bench can sweep every amplitude, frequency and unbalance code against the entry windows. It can also ramp toward every possible target from the trial level.

The short timers make it cheap to break the dwell at each position and to inject a fault in each trial cycle. The bench also drives every trip cause in every supervised stage, and checks the cause priority and the full hold-off.

// File: rtl/grid_sync_seq.sv
module grid_sync_seq #(
  parameter int AW = 12,
  parameter int FW = 16,
  parameter int UW = 10,
  parameter int PEW = 12,
  parameter int PW = 16,
  parameter int CW = 16,
  parameter int AMP_MIN = 1843,
  parameter int AMP_MAX = 2253,
  parameter int FREQ_MIN = 49500,
  parameter int FREQ_MAX = 50500,
  parameter int UNBAL_MAX = 40,
  parameter int ROCOF_MAX = 20,
  parameter int PJUMP_MAX = 455,
  parameter int LOCK_ERR_MAX = 45,
  parameter int DWELL = 2000,
  parameter int TRIAL_LEN = 5000,
  parameter int TRIAL_P = 200,
  parameter int STEP = 16,
  parameter int HOLDOFF = 30000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         amp,
  input  logic [FW-1:0]         freq,
  input  logic [UW-1:0]         unbal,
  input  logic                  pll_lock,
  input  logic signed [PEW-1:0] phase_err,
  input  logic                  cur_fault,
  input  logic                  prot_fault,
  input  logic [PW-1:0]         p_target,
  output logic                  connect,
  output logic [PW-1:0]         p_ref,
  output logic [2:0]            state,
  output logic [2:0]            trip_code
);

  localparam logic [AW-1:0]  AMIN  = AW'(AMP_MIN);
  localparam logic [AW-1:0]  AMAX  = AW'(AMP_MAX);
  localparam logic [FW-1:0]  FMIN  = FW'(FREQ_MIN);
  localparam logic [FW-1:0]  FMAX  = FW'(FREQ_MAX);
  localparam logic [UW-1:0]  UMAX  = UW'(UNBAL_MAX);
  localparam logic [FW-1:0]  RMAX  = FW'(ROCOF_MAX);
  localparam logic [PEW-1:0] JMAX  = PEW'(PJUMP_MAX);
  localparam logic [PEW-1:0] LKMAX = PEW'(LOCK_ERR_MAX);
  localparam logic [PW-1:0]  TRP   = PW'(TRIAL_P);
  localparam logic [PW-1:0]  STP   = PW'(STEP);
  localparam logic [CW-1:0]  DWELL_LAST = CW'(DWELL - 1);
  localparam logic [CW-1:0]  TRIAL_LAST = CW'(TRIAL_LEN - 1);
  localparam logic [CW-1:0]  HOLD_LAST  = CW'(HOLDOFF - 1);

  typedef enum logic [2:0] {
    S_WAIT = 3'd0, S_DWELL = 3'd1, S_TRIAL = 3'd2,
    S_RAMP = 3'd3, S_RUN = 3'd4, S_TRIP = 3'd5
  } st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [FW-1:0]  f_prev;
  logic [2:0]     cause;

  wire [FW-1:0]  f_diff = (freq >= f_prev) ? freq - f_prev : f_prev - freq;
  wire [PEW-1:0] pe_abs = phase_err[PEW-1] ? PEW'(-phase_err) : PEW'(phase_err);

  wire amp_ok   = (amp >= AMIN) && (amp <= AMAX);
  wire frq_ok   = (freq >= FMIN) && (freq <= FMAX);
  wire unb_ok   = unbal <= UMAX;
  wire stable   = pll_lock && (pe_abs <= LKMAX);
  wire watching = (st == S_DWELL) || connect;
  wire trip_now = watching && (cause != 3'd0);

  wire          up      = p_ref < p_target;
  wire [PW-1:0] gap     = up ? p_target - p_ref : p_ref - p_target;
  wire [PW-1:0] mv      = (gap > STP) ? STP : gap;
  wire [PW-1:0] p_next  = up ? p_ref + mv : p_ref - mv;

  assign connect = (st == S_TRIAL) || (st == S_RAMP) || (st == S_RUN);
  assign state   = st;

  always_comb begin
    if (!amp_ok)                 cause = 3'd1;
    else if (!frq_ok)            cause = 3'd2;
    else if (f_diff > RMAX)      cause = 3'd3;
    else if (pe_abs > JMAX)      cause = 3'd4;
    else if (st == S_TRIAL && (cur_fault || prot_fault)) cause = 3'd5;
    else                         cause = 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_WAIT;
      cnt       <= '0;
      p_ref     <= '0;
      trip_code <= 3'd0;
      f_prev    <= '0;
    end else begin
      f_prev <= freq;
      if (trip_now) begin
        st        <= S_TRIP;
        cnt       <= '0;
        p_ref     <= '0;
        trip_code <= cause;
      end else begin
        case (st)
          S_WAIT:
            if (amp_ok && frq_ok && unb_ok) begin
              st  <= S_DWELL;
              cnt <= '0;
            end
          S_DWELL:
            if (!stable) cnt <= '0;
            else if (cnt == DWELL_LAST) begin
              st    <= S_TRIAL;
              cnt   <= '0;
              p_ref <= TRP;
            end else cnt <= cnt + 1'b1;
          S_TRIAL:
            if (cnt == TRIAL_LAST) begin
              st  <= S_RAMP;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          S_RAMP: begin
            p_ref <= p_next;
            if (p_next == p_target) st <= S_RUN;
          end
          S_RUN: p_ref <= p_next;
          S_TRIP:
            if (cnt == HOLD_LAST) begin
              st  <= S_WAIT;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          default: st <= S_WAIT;
        endcase
      end
    end
  end

endmodule

// File: rtl/grid_sync_seq_chk.sv
module grid_sync_seq_chk #(
  parameter int PW = 16,
  parameter int TRIAL_P = 200,
  parameter int STEP = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          connect,
  input logic [PW-1:0] p_ref,
  input logic [2:0]    state,
  input logic [2:0]    trip_code
);

  logic [PW-1:0] p_prev;
  logic [2:0]    s_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_prev <= '0;
      s_prev <= 3'd0;
    end else begin
      p_prev <= p_ref;
      s_prev <= state;
    end
  end

  wire          ramping = (state == 3'd3 || state == 3'd4) && (s_prev == 3'd3 || s_prev == 3'd4);
  wire [PW-1:0] delta   = (p_ref >= p_prev) ? p_ref - p_prev : p_prev - p_ref;

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'd5);

  assert_trial_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connect) |-> (state == 3'd2 && p_ref == PW'(TRIAL_P)));

  assert_rate_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ramping |-> delta <= PW'(STEP));

  assert_trip_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd5 |-> trip_code != 3'd0);

  assert_drop_only_on_trip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(connect) |-> state == 3'd5);

  assert_idle_ref_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !connect |-> p_ref == '0);

  assert_connect_states_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 || state == 3'd1 || state == 3'd5) |-> !connect);

endmodule

bind grid_sync_seq grid_sync_seq_chk #(.PW(PW), .TRIAL_P(TRIAL_P), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .connect(connect), .p_ref(p_ref),
  .state(state), .trip_code(trip_code)
);

// File: tb/tb_grid_sync_seq.sv
module tb_grid_sync_seq;

  localparam int W = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [W-1:0]       amp, freq, p_target;
  logic [5:0]         unbal;
  logic               pll_lock, cur_fault, prot_fault;
  logic signed [W-1:0] phase_err;
  logic               connect;
  logic [W-1:0]       p_ref;
  logic [2:0]         state, trip_code;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  grid_sync_seq #(
    .AW(W), .FW(W), .UW(6), .PEW(W), .PW(W), .CW(W),
    .AMP_MIN(100), .AMP_MAX(150), .FREQ_MIN(60), .FREQ_MAX(80),
    .UNBAL_MAX(10), .ROCOF_MAX(3), .PJUMP_MAX(40), .LOCK_ERR_MAX(5),
    .DWELL(4), .TRIAL_LEN(3), .TRIAL_P(10), .STEP(7), .HOLDOFF(5)
  ) dut (
    .clk(clk), .rst_n(rst_n), .amp(amp), .freq(freq), .unbal(unbal),
    .pll_lock(pll_lock), .phase_err(phase_err), .cur_fault(cur_fault),
    .prot_fault(prot_fault), .p_target(p_target), .connect(connect),
    .p_ref(p_ref), .state(state), .trip_code(trip_code)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic set_good(input int tgt);
    amp = 8'd125; freq = 8'd70; unbal = 6'd0; pll_lock = 1'b1;
    phase_err = 8'sd0; cur_fault = 1'b0; prot_fault = 1'b0;
    p_target = W'(tgt);
  endtask

  task automatic do_reset(input int tgt);
    rst_n = 1'b0;
    set_good(tgt);
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic goto(input int s, input int tgt);
    do_reset(tgt);
    tick();
    if (s >= 2) repeat (4) tick();
    if (s >= 3) repeat (3) tick();
    if (s >= 4) begin
      p_target = 8'd17;
      tick();
      p_target = W'(tgt);
    end
  endtask

  task automatic violate(input int c);
    case (c)
      1: amp = 8'd151;
      2: freq = 8'd81;
      3: freq = 8'd74;
      default: phase_err = -8'sd41;
    endcase
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int p, e;
    do_reset(50);
    rst_n = 1'b0;
    tick();
    chk("R1 state", state, 0);
    chk("R1 connect", connect, 0);
    chk("R1 p_ref", p_ref, 0);
    chk("R1 trip_code", trip_code, 0);
    rst_n = 1'b1;

    for (int a = 0; a < 256; a++) begin
      do_reset(50); amp = W'(a); tick();
      chk("R2 amp window", state, (a >= 100 && a <= 150) ? 1 : 0);
    end
    for (int f = 0; f < 256; f++) begin
      do_reset(50); freq = W'(f); tick();
      chk("R2 freq window", state, (f >= 60 && f <= 80) ? 1 : 0);
    end
    for (int u = 0; u < 64; u++) begin
      do_reset(50); unbal = 6'(u); tick();
      chk("R2 unbal window", state, (u <= 10) ? 1 : 0);
    end

    goto(1, 50);
    repeat (3) tick();
    chk("R3 dwell not done", state, 1);
    tick();
    chk("R3 dwell done", state, 2);
    for (int k = 0; k < 4; k++) begin
      for (int m = 0; m < 2; m++) begin
        goto(1, 50);
        repeat (k) tick();
        if (m == 0) pll_lock = 1'b0; else phase_err = 8'sd6;
        tick();
        chk("R3 unstable stays", state, 1);
        set_good(50);
        repeat (3) tick();
        chk("R3 restarted count", state, 1);
        tick();
        chk("R3 trial after restart", state, 2);
      end
    end

    goto(2, 50);
    chk("R4 trial p_ref", p_ref, 10);
    chk("R11 trial connect", connect, 1);
    tick(); tick();
    chk("R4 still trial", state, 2);
    tick();
    chk("R4 ramp after clean trial", state, 3);
    chk("R11 ramp connect", connect, 1);
    for (int j = 0; j < 3; j++) begin
      for (int m = 0; m < 2; m++) begin
        goto(2, 50);
        repeat (j) tick();
        if (m == 0) cur_fault = 1'b1; else prot_fault = 1'b1;
        tick();
        chk("R4 trial fault state", state, 5);
        chk("R4 trial fault code", trip_code, 5);
        chk("R10 trial fault connect", connect, 0);
        chk("R10 trial fault p_ref", p_ref, 0);
      end
    end

    for (int t = 0; t < 256; t++) begin
      goto(3, t);
      p = 10;
      for (int i = 0; i < 64; i++) begin
        e = (t > p) ? ((t - p > 7) ? p + 7 : t) : ((p - t > 7) ? p - 7 : t);
        tick();
        chk("R5 ramp p_ref", p_ref, e);
        chk("R5 ramp state", state, (e == t) ? 4 : 3);
        p = e;
        if (e == t) break;
      end
    end
    goto(4, 17);
    chk("R5 run reached", state, 4);
    chk("R11 run connect", connect, 1);
    p_target = 8'd0;
    p = 17;
    for (int i = 0; i < 4; i++) begin
      e = (p > 7) ? p - 7 : 0;
      tick();
      chk("R5 run tracks down", p_ref, e);
      chk("R5 run stays", state, 4);
      p = e;
    end

    for (int s = 1; s <= 4; s++) begin
      for (int c = 1; c <= 4; c++) begin
        goto(s, 50);
        violate(c);
        tick();
        chk(c == 1 ? "R6 amp trip" : c == 2 ? "R6 freq trip" : c == 3 ? "R7 rocof trip" : "R8 jump trip",
            trip_code, c);
        chk("R10 trip state", state, 5);
        chk("R10 trip connect", connect, 0);
        chk("R10 trip p_ref", p_ref, 0);
      end
    end
    goto(3, 50);
    freq = 8'd73; tick();
    chk("R7 slew at limit no trip", state, 3);
    freq = 8'd76; tick();
    chk("R7 slew at limit no trip again", state, 3);
    phase_err = 8'sd40; tick();
    chk("R8 jump at limit no trip", state, 3);
    phase_err = 8'sd41; tick();
    chk("R8 positive jump trips", trip_code, 4);

    goto(3, 50);
    amp = 8'd200; freq = 8'd90; phase_err = 8'sd100; tick();
    chk("R9 amp wins", trip_code, 1);
    goto(3, 50);
    freq = 8'd90; phase_err = 8'sd100; tick();
    chk("R9 freq wins", trip_code, 2);
    goto(3, 50);
    freq = 8'd75; phase_err = 8'sd100; tick();
    chk("R9 rocof wins", trip_code, 3);
    goto(2, 50);
    cur_fault = 1'b1; phase_err = 8'sd100; tick();
    chk("R9 jump beats trial fault", trip_code, 4);

    set_good(50);
    repeat (4) begin
      tick();
      chk("R10 hold-off stays tripped", state, 5);
    end
    tick();
    chk("R10 hold-off ends", state, 0);
    chk("R9 code held in wait", trip_code, 4);
    tick();
    chk("R2 rearm after hold-off", state, 1);
    chk("R9 code still held", trip_code, 4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule